// File: doc/BRIEF.md
# UART Receive Character-to-Byte Packer

This block sits between a UART receiver front end and an 8-bit receive FIFO. Each received character arrives as a one-cycle strobe with up to nine data bits and four condition flags: parity error, framing error, break and overrun. The block turns the character into bytes on a valid/ready stream that feeds the FIFO.

In normal mode each character gives one byte. In wide mode each character gives a data byte followed by a status byte that carries its condition flags. A sticky error register sits beside the stream. It gathers the flags of every character and clears when it is read.

The packer holds at most one character's bytes at a time. A character that arrives while bytes are still waiting is thrown away. The loss is then reported as an overrun.

Top module: `uart_rx_packer`

## Requirements
- R1: The data byte carries character bits 0 up to the character length minus one. Bit positions at or above the length read 0, so 5, 6 and 7-bit characters have zero upper bits. For 8 and 9-bit characters the byte is bits 7:0. `cfg_len` holds the length as a plain number from 5 to 9.
- R2: When `cfg_wide`=0, each stored character produces exactly one output byte. For 9-bit characters this means bit 8 and all of the character's flags are left out of the stream.
- R3: When `cfg_wide`=1, each stored character produces exactly two output bytes: the data byte first, then the status byte.
- R4: Status byte layout for 5 to 8-bit characters: bit0 = parity error, bit1 = break, bit2 = framing error, bit3 = overrun, bits 7:4 = 0. Bit0 is 0 whenever `cfg_par_en`=0.
- R5: For 9-bit characters in wide mode, status bit0 holds data bit 8 in place of parity error. Bits 3:1 keep the same meaning as in R4.
- R6: While `out_valid`=1 and `out_ready`=0, `out_valid` stays 1 and `out_data` stays stable. The two bytes of a wide pair come out back to back, with no byte of another character between them.
- R7: A character strobed while `out_valid`=1 is discarded and none of its bytes reach the stream. Its loss sets `err_flags` bit3. It also sets bit3 of the status byte of the next character that is stored.
- R8: `err_flags` uses the same bit layout as the status byte's low nibble. Each bit is set by the matching flag of any stored character, with parity gated by `cfg_par_en`. Each bit stays set until a read.
- R9: A cycle with `err_rd`=1 clears `err_flags` at the next clock. An error that is recorded in that same cycle is still set afterwards.
- R10: While the synchronous active-low reset `rst_n` is low, the pending bytes, the overrun carry and the sticky flags all clear. After reset, `out_valid`=0 and `err_flags`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_len | input | 4 | Character length in bits (5..9) |
| cfg_wide | input | 1 | 1 = write a status byte after each data byte |
| cfg_par_en | input | 1 | 1 = parity checking is enabled |
| ch_valid | input | 1 | One-cycle strobe: a received character is present |
| ch_data | input | 9 | Received character bits, LSB first bit |
| ch_perr | input | 1 | Parity error for this character |
| ch_ferr | input | 1 | Framing error for this character |
| ch_brk | input | 1 | Break detected |
| ch_ovr | input | 1 | Front-end overrun reported with this character |
| out_valid | output | 1 | A byte is offered to the FIFO |
| out_data | output | 8 | Byte offered to the FIFO |
| out_ready | input | 1 | FIFO accepts the byte this cycle |
| err_rd | input | 1 | Read strobe for the sticky error flags |
| err_flags | output | 4 | Sticky flags {overrun, framing, break, parity} |

## Verification
The bench builds the block with its default byte width of 8, which gives a 9-bit maximum character. This width is small enough to sweep every character length from 5 to 9. For each length it covers both modes, both parity settings and all sixteen flag combinations, over a spread of data words that includes all zeros and all ones. A repeating back-pressure pattern on `out_ready` produces stalls in the middle of wide pairs. Directed sequences cover a character dropped while the block is busy, the overrun carried into the next status byte, and an error that arrives in the same cycle as a read.

// File: rtl/uart_rxpk_pkg.sv
// Package: shared widths and flag type for the receive byte packer.
// Assumes a character is at most one bit wider than a FIFO byte.
package uart_rxpk_pkg;
    localparam int RXPK_BYTE_W = 8;
    localparam int RXPK_FLAG_W = 4;

    // Flag set in status-byte bit order (MSB first in the struct).
    typedef struct packed {
        logic ovr;
        logic ferr;
        logic brk;
        logic perr;
    } rxpk_flags_t;
endpackage

// File: rtl/rxpk_format.sv
// Module: rxpk_format
// Combinational. Builds the data byte and the status byte for one character,
// and the set of errors that character contributes to the sticky register.
// Assumes CHAR_W == BYTE_W + 1; the top bit is the optional ninth data bit.
module rxpk_format
    import uart_rxpk_pkg::*;
#(
    parameter int BYTE_W = RXPK_BYTE_W,
    parameter int LEN_W  = 4,
    localparam int CHAR_W = BYTE_W + 1
) (
    input  logic [LEN_W-1:0]  cfg_len,
    input  logic              cfg_par_en,
    input  logic [CHAR_W-1:0] ch_data,
    input  rxpk_flags_t       ch_flags,
    input  logic              carry_ovr,
    output logic [BYTE_W-1:0] data_byte,
    output logic [BYTE_W-1:0] stat_byte,
    output rxpk_flags_t       err_new
);
    logic nine_bit;

    // Character holds the extra bit when length reaches CHAR_W.
    assign nine_bit = (int'(cfg_len) >= CHAR_W);

    // Per-bit mask: keep a data bit only when it lies below the length.
    for (genvar gi = 0; gi < BYTE_W; gi++) begin : g_mask
        assign data_byte[gi] = ch_data[gi] & (int'(cfg_len) > gi);
    end

    // Status byte: low nibble of flags, ninth bit replacing parity when used.
    always_comb begin
        stat_byte    = '0;
        stat_byte[0] = nine_bit ? ch_data[CHAR_W-1] : (ch_flags.perr & cfg_par_en);
        stat_byte[1] = ch_flags.brk;
        stat_byte[2] = ch_flags.ferr;
        stat_byte[3] = ch_flags.ovr | carry_ovr;
    end

    // Errors recorded in the sticky register for this character.
    always_comb begin
        err_new      = ch_flags;
        err_new.perr = ch_flags.perr & cfg_par_en;
    end
endmodule

// File: rtl/rxpk_outq.sv
// Module: rxpk_outq
// Two-entry output holder with a valid/ready port. It is loaded with one or
// two bytes at once, and only while it is empty.
// Assumes the caller never asserts load while busy.
module rxpk_outq #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              load_two,
    input  logic [BYTE_W-1:0] first_byte,
    input  logic [BYTE_W-1:0] second_byte,
    output logic              out_valid,
    output logic [BYTE_W-1:0] out_data,
    input  logic              out_ready
);
    logic [1:0]        cnt_q;
    logic [BYTE_W-1:0] head_q;
    logic [BYTE_W-1:0] next_q;

    assign out_valid = (cnt_q != 2'd0);
    assign out_data  = head_q;

    // Load a fresh pair or shift one byte out per completed handshake.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= 2'd0;
            head_q <= '0;
            next_q <= '0;
        end else if (load) begin
            head_q <= first_byte;
            next_q <= second_byte;
            cnt_q  <= load_two ? 2'd2 : 2'd1;
        end else if (out_valid && out_ready) begin
            head_q <= next_q;
            cnt_q  <= cnt_q - 2'd1;
        end
    end

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data))); // R6
    AST_PAIR_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && cnt_q == 2'd2) |=> out_valid); // R3
    AST_LOAD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> !out_valid); // R7
endmodule

// File: rtl/rxpk_sticky.sv
// Module: rxpk_sticky
// Sticky error flags. A bit sets on any report, and a read clears the bits.
// A report in the same cycle as a read survives the clear.
module rxpk_sticky #(
    parameter int FLAG_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [FLAG_W-1:0] set_vec,
    input  logic              rd,
    output logic [FLAG_W-1:0] flags
);
    logic [FLAG_W-1:0] flags_q;

    assign flags = flags_q;

    // Accumulate reports; clear on read except for reports arriving now.
    always_ff @(posedge clk) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= (rd ? '0 : flags_q) | set_vec;
    end

    AST_STICKY_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        !rd |=> (($past(flags_q) & ~flags_q) == '0)); // R8
    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && set_vec == '0) |=> (flags_q == '0)); // R9
endmodule

// File: rtl/uart_rx_packer.sv
// Module: uart_rx_packer (top)
// Packs received UART characters into bytes for an 8-bit receive FIFO.
// In normal mode each character gives one data byte. In wide mode it gives
// a data byte and then a status byte. Characters that arrive while bytes are
// pending are dropped, and the drop is reported as an overrun.
// Assumes ch_valid is a single-cycle strobe per character.
module uart_rx_packer
    import uart_rxpk_pkg::*;
#(
    parameter int BYTE_W = RXPK_BYTE_W,
    parameter int LEN_W  = 4,
    localparam int CHAR_W = BYTE_W + 1,
    localparam int FLAG_W = RXPK_FLAG_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LEN_W-1:0]  cfg_len,
    input  logic              cfg_wide,
    input  logic              cfg_par_en,
    input  logic              ch_valid,
    input  logic [CHAR_W-1:0] ch_data,
    input  logic              ch_perr,
    input  logic              ch_ferr,
    input  logic              ch_brk,
    input  logic              ch_ovr,
    output logic              out_valid,
    output logic [BYTE_W-1:0] out_data,
    input  logic              out_ready,
    input  logic              err_rd,
    output logic [FLAG_W-1:0] err_flags
);
    rxpk_flags_t       flags_in;
    rxpk_flags_t       err_new;
    logic [BYTE_W-1:0] data_byte;
    logic [BYTE_W-1:0] stat_byte;
    logic              accept;
    logic              drop;
    logic              carry_ovr_q;
    logic [FLAG_W-1:0] set_vec;

    assign flags_in = '{ovr: ch_ovr, ferr: ch_ferr, brk: ch_brk, perr: ch_perr};
    assign accept   = ch_valid && !out_valid;
    assign drop     = ch_valid &&  out_valid;

    // Errors of a stored character plus an overrun for a dropped one.
    always_comb begin
        set_vec    = accept ? FLAG_W'(err_new) : '0;
        set_vec[3] = set_vec[3] | drop;
    end

    // Remember a drop until the next stored character carries it.
    always_ff @(posedge clk) begin
        if (!rst_n)      carry_ovr_q <= 1'b0;
        else if (accept) carry_ovr_q <= 1'b0;
        else if (drop)   carry_ovr_q <= 1'b1;
    end

    rxpk_format #(.BYTE_W(BYTE_W), .LEN_W(LEN_W)) i_format (
        .cfg_len    (cfg_len),
        .cfg_par_en (cfg_par_en),
        .ch_data    (ch_data),
        .ch_flags   (flags_in),
        .carry_ovr  (carry_ovr_q),
        .data_byte  (data_byte),
        .stat_byte  (stat_byte),
        .err_new    (err_new)
    );

    rxpk_outq #(.BYTE_W(BYTE_W)) i_outq (
        .clk         (clk),
        .rst_n       (rst_n),
        .load        (accept),
        .load_two    (cfg_wide),
        .first_byte  (data_byte),
        .second_byte (stat_byte),
        .out_valid   (out_valid),
        .out_data    (out_data),
        .out_ready   (out_ready)
    );

    rxpk_sticky #(.FLAG_W(FLAG_W)) i_sticky (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_vec (set_vec),
        .rd      (err_rd),
        .flags   (err_flags)
    );

    AST_DROP_OVERRUN: assert property (@(posedge clk) disable iff (!rst_n)
        (ch_valid && out_valid) |=> err_flags[3]); // R7
    AST_ACCEPT_OFFERS: assert property (@(posedge clk) disable iff (!rst_n)
        (ch_valid && !out_valid) |=> out_valid); // R2
    AST_WIDE_PAR_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        (ch_valid && !out_valid && !cfg_par_en && !err_rd && err_flags[0] == 1'b0) |=> !err_flags[0]); // R4
endmodule

// File: tb/test_uart_rx_packer.sv
module test_uart_rx_packer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] cfg_len = 4'd8;
    logic       cfg_wide = 1'b0;
    logic       cfg_par_en = 1'b0;
    logic       ch_valid = 1'b0;
    logic [8:0] ch_data = '0;
    logic       ch_perr = 1'b0, ch_ferr = 1'b0, ch_brk = 1'b0, ch_ovr = 1'b0;
    logic       out_valid;
    logic [7:0] out_data;
    logic       out_ready = 1'b1;
    logic       err_rd = 1'b0;
    logic [3:0] err_flags;
    logic       stall_en = 1'b0;

    int vectors = 0;
    int fails = 0;
    int cyc = 0;

    uart_rx_packer i_uart_rx_packer (
        .clk(clk), .rst_n(rst_n), .cfg_len(cfg_len), .cfg_wide(cfg_wide),
        .cfg_par_en(cfg_par_en), .ch_valid(ch_valid), .ch_data(ch_data),
        .ch_perr(ch_perr), .ch_ferr(ch_ferr), .ch_brk(ch_brk), .ch_ovr(ch_ovr),
        .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready),
        .err_rd(err_rd), .err_flags(err_flags)
    );

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input int act, input int exp, input string req);
        vectors++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    // Strobe one character for a single cycle from the idle state.
    task automatic send_char(input logic [8:0] d, input logic [3:0] f);
        @(negedge clk);
        ch_data = d; ch_perr = f[0]; ch_brk = f[1]; ch_ferr = f[2]; ch_ovr = f[3];
        ch_valid = 1'b1;
        @(negedge clk);
        ch_valid = 1'b0;
    endtask

    // Wait for one byte (with optional back-pressure) and compare it.
    task automatic get_byte(input int exp, input string req);
        logic       held_v = 1'b0;
        logic [7:0] held_d = '0;
        for (int w = 0; w < 40; w++) begin
            out_ready = stall_en ? (cyc % 3 != 1) : 1'b1;
            #1;
            if (held_v && out_valid) chk(out_data, held_d, "R6 hold");
            if (out_valid && out_ready) begin
                chk(out_data, exp, req);
                @(negedge clk);
                out_ready = 1'b1;
                return;
            end
            held_v = out_valid;
            held_d = out_data;
            @(negedge clk);
        end
        chk(0, 1, {req, " timeout"});
    endtask

    task automatic read_flags(input int exp, input string req);
        chk(err_flags, exp, req);
        err_rd = 1'b1;
        @(negedge clk);
        err_rd = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog act=expired exp=done");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(out_valid, 0, "R10 out_valid");
        chk(err_flags, 0, "R10 err_flags");

        // Sweep over length, mode, parity enable, data and flag combinations.
        for (int len = 5; len <= 9; len++) begin
            for (int wide = 0; wide < 2; wide++) begin
                for (int pe = 0; pe < 2; pe++) begin
                    for (int k = 0; k < 32; k++) begin
                        for (int f = 0; f < 16; f++) begin
                            logic [8:0] d;
                            int keep, edat, est, eflg;
                            d = (k == 31) ? 9'h1FF : 9'((k * 37 + len * 5 + f * 11) % 512);
                            keep = (len >= 8) ? 8 : len;
                            edat = int'(d[7:0]) & ((1 << keep) - 1);
                            est = (f[3] << 3) | (f[2] << 2) | (f[1] << 1) |
                                  ((len == 9) ? int'(d[8]) : (f[0] & pe));
                            eflg = (f[3] << 3) | (f[2] << 2) | (f[1] << 1) | (f[0] & pe);
                            cfg_len = 4'(len); cfg_wide = wide[0]; cfg_par_en = pe[0];
                            stall_en = ((k + f) % 4 == 0);
                            send_char(d, f[3:0]);
                            get_byte(edat, "R1 data byte");
                            if (wide != 0)
                                get_byte(est, (len == 9) ? "R5 status byte" : "R4 status byte");
                            chk(out_valid, 0, wide != 0 ? "R3 byte count" : "R2 byte count");
                            read_flags(eflg, "R8 sticky");
                        end
                    end
                end
            end
        end

        // R7: drop while busy, overrun carried into next status byte.
        cfg_len = 4'd8; cfg_wide = 1'b1; cfg_par_en = 1'b0; stall_en = 1'b0;
        out_ready = 1'b0;
        @(negedge clk);
        ch_data = 9'h0A5; {ch_ovr, ch_ferr, ch_brk, ch_perr} = 4'b0000; ch_valid = 1'b1;
        @(negedge clk);
        ch_data = 9'h03C; ch_valid = 1'b1;
        @(negedge clk);
        ch_valid = 1'b0;
        chk(err_flags, 4'h8, "R7 sticky overrun");
        chk(out_data, 8'hA5, "R7 first kept");
        get_byte(8'hA5, "R7 data A");
        get_byte(8'h00, "R7 status A");
        chk(out_valid, 0, "R7 dropped char absent");
        send_char(9'h011, 4'b0000);
        get_byte(8'h11, "R7 data C");
        get_byte(8'h08, "R7 carried overrun");
        read_flags(4'h8, "R7 sticky after");
        send_char(9'h022, 4'b0000);
        get_byte(8'h22, "R7 carry cleared data");
        get_byte(8'h00, "R7 carry cleared status");

        // R9: error arriving in the read cycle survives the clear.
        cfg_wide = 1'b0;
        send_char(9'h055, 4'b0010);
        get_byte(8'h55, "R9 setup");
        chk(err_flags, 4'h2, "R9 before");
        @(negedge clk);
        ch_data = 9'h066; ch_ferr = 1'b1; ch_brk = 1'b0; ch_perr = 1'b0; ch_ovr = 1'b0;
        ch_valid = 1'b1; err_rd = 1'b1;
        @(negedge clk);
        ch_valid = 1'b0; err_rd = 1'b0;
        chk(err_flags, 4'h4, "R9 same-cycle error kept");
        get_byte(8'h66, "R9 data");
        read_flags(4'h4, "R9 read");
        chk(err_flags, 0, "R9 cleared");

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule